// File: doc/BRIEF.md
# Scaled Variable-Depth Pixel Serializer

This block turns one fetched video byte into a run of pixels. Each pixel takes 1, 2 or 4 bits of the byte, so one byte yields 8, 4 or 2 pixels. The leftmost (most significant) bits come out first. Each pixel can be held on the output for 1, 2 or 4 clock steps. There is no divider for this stretching. The block reads the 8-bit one-hot phase ring of the memory sequencer and advances only on phases that a fixed mask selects for the chosen scale.

A load strobe latches a new byte, and its first pixel appears at once. While no pixels are pending, the output shows the blank colour, which is pixel value zero with the blank flag raised. A load that lands on the edge where the previous byte ends takes priority over the end. The new byte's pixels then follow with no blank gap. The depth select must be held steady while a byte is being emitted.

Top module: `pix_serializer`

## Requirements
- R1: After reset, and with no load since then, blank_o is 1 and pix_o is 0.
- R2: In the cycle after an edge with load_i high, blank_o is 0 and pix_o shows the top pixel of byte_i.
- R3: While no pixels are pending, blank_o is 1 and pix_o is 0. This state persists until the next load.
- R4: depth_i encoding: 00 gives 1 bit per pixel, 01 gives 2 bits, and 10 or 11 give 4 bits. Each pixel is the next most significant unused bits of the byte, zero-extended into the low bits of pix_o.
- R5: A byte yields exactly 8, 4 or 2 pixels at 1, 2 or 4 bits per pixel. After the last pixel the output goes blank.
- R6: scale_i = 00 advances to the next pixel on every clock edge.
- R7: scale_i = 01 advances only on edges where phase_i AND 8'hAA is nonzero.
- R8: scale_i = 10 or 11 advances only on edges where phase_i AND 8'h88 is nonzero.
- R9: A load on the edge that would end the current byte shows the new byte's first pixel in the next cycle, with no blank cycle.
- R10: A load in the middle of a byte discards the remaining pixels and restarts from the new byte.
- R11: At scale_i = 00 the value of phase_i has no effect. Pixels still advance with phase_i held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one phase step per edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Latch byte_i as new pixel data |
| byte_i | input | 8 | Fetched video byte |
| depth_i | input | 2 | Bits per pixel select |
| scale_i | input | 2 | Horizontal stretch select |
| phase_i | input | 8 | One-hot memory sequencer phase |
| pix_o | output | 4 | Current pixel value, zero-extended |
| blank_o | output | 1 | High while no pixels are pending |

## Verification
The same asymmetric bytes are used at each depth, so a pixel order reversed in bit or nibble shows up as a mismatch. Running each scale against the rotating phase ring separates the two phase masks from each other and from full rate. A run at full rate with the phase held at zero shows that the mask is bypassed at that scale. Loads on the last advance, in mid-byte and after idle gaps separate the priority between load and end, restart, and the blank gap.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PIX_W   = 4;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NBITS_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SCALE_X1 = 2'b00,
    SCALE_X2 = 2'b01,
    SCALE_X4 = 2'b10,
    SCALE_X4_ALT = 2'b11
  } scale_e;

  // bits consumed per pixel for a depth select
  function automatic logic [NBITS_W-1:0] depth_bits(input logic [SEL_W-1:0] sel);
    unique case (sel)
      2'b00:   depth_bits = 3'd1;
      2'b01:   depth_bits = 3'd2;
      default: depth_bits = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pix_step_gate.sv
module pix_step_gate
  import pix_ser_pkg::*;
#(
  parameter int unsigned PHASE_W   = 8,
  parameter logic [PHASE_W-1:0] HALF_MASK    = 8'hAA,
  parameter logic [PHASE_W-1:0] QUARTER_MASK = 8'h88
) (
  input  logic [SEL_W-1:0]   scale_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               step_o
);
  logic half_hit, quarter_hit;

  assign half_hit    = |(phase_i & HALF_MASK);
  assign quarter_hit = |(phase_i & QUARTER_MASK);

  always_comb begin
    unique case (scale_e'(scale_i))
      SCALE_X1: step_o = 1'b1;
      SCALE_X2: step_o = half_hit;
      default:  step_o = quarter_hit;
    endcase
  end
endmodule

// File: rtl/pix_tracker.sv
module pix_tracker
  import pix_ser_pkg::*;
#(
  parameter int unsigned RING_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [NBITS_W-1:0] nbits_i,
  output logic [RING_W-1:0]  trk_o,
  output logic               active_o
);
  localparam logic [RING_W-1:0] START = RING_W'(1);

  logic [RING_W-1:0] trk_q, rot;

  // rotate left by the pixel width, top bits wrap to the bottom
  assign rot = (trk_q << nbits_i) | (trk_q >> (RING_W - 32'(nbits_i)));
  assign active_o = |trk_q;
  assign trk_o    = trk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q <= '0;
    end else if (load_i) begin
      trk_q <= START;
    end else if (active_o && step_i) begin
      trk_q <= (rot == START) ? '0 : rot;
    end
  end
endmodule

// File: rtl/pix_shifter.sv
module pix_shifter
  import pix_ser_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [DW-1:0]      byte_i,
  input  logic [NBITS_W-1:0] nbits_i,
  output logic [PW-1:0]      pix_o
);
  logic [DW-1:0] sd_q;
  logic [PW-1:0] top;

  assign top   = sd_q[DW-1 -: PW];
  assign pix_o = top >> (PW - 32'(nbits_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q <= '0;
    end else if (load_i) begin
      sd_q <= byte_i;
    end else if (adv_i) begin
      sd_q <= sd_q << nbits_i;
    end
  end
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
#(
  parameter int unsigned PHASE_W = 8,
  parameter logic [PHASE_W-1:0] HALF_MASK    = 8'hAA,
  parameter logic [PHASE_W-1:0] QUARTER_MASK = 8'h88
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DATA_W-1:0]  byte_i,
  input  logic [SEL_W-1:0]   depth_i,
  input  logic [SEL_W-1:0]   scale_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [PIX_W-1:0]   pix_o,
  output logic               blank_o
);
  localparam int unsigned RING_W = DATA_W;

  logic [NBITS_W-1:0] nbits;
  logic               step, active, adv;
  logic [RING_W-1:0]  trk;

  assign nbits = depth_bits(depth_i);
  assign adv   = active && step && !load_i;

  pix_step_gate #(
    .PHASE_W(PHASE_W), .HALF_MASK(HALF_MASK), .QUARTER_MASK(QUARTER_MASK)
  ) u_gate (
    .scale_i(scale_i), .phase_i(phase_i), .step_o(step)
  );

  pix_tracker #(.RING_W(RING_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step),
    .nbits_i(nbits), .trk_o(trk), .active_o(active)
  );

  pix_shifter #(.DW(DATA_W), .PW(PIX_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .adv_i(adv),
    .byte_i(byte_i), .nbits_i(nbits), .pix_o(pix_o)
  );

  assign blank_o = !active;
endmodule

// File: rtl/pix_serializer_chk.sv
module pix_serializer_chk #(
  parameter int unsigned PHASE_W = 8,
  parameter logic [PHASE_W-1:0] HALF_MASK    = 8'hAA,
  parameter logic [PHASE_W-1:0] QUARTER_MASK = 8'h88
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [1:0]         depth_i,
  input logic [1:0]         scale_i,
  input logic [PHASE_W-1:0] phase_i,
  input logic [3:0]         pix_o,
  input logic               blank_o,
  input logic [7:0]         trk
);
  p_load_shows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!blank_o && trk == 8'd1));

  p_stay_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_o && !load_i) |=> blank_o);

  p_blank_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> (pix_o == 4'd0));

  p_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == 2'b00) |-> (pix_o[3:1] == 3'd0));

  p_ring_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trk));

  p_full_rate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !blank_o && scale_i == 2'b00) |=> (trk != $past(trk)));

  p_hold_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !blank_o && scale_i == 2'b01 && (phase_i & HALF_MASK) == '0)
    |=> (!blank_o && $stable(trk)));

  p_hold_quarter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !blank_o && scale_i[1] && (phase_i & QUARTER_MASK) == '0)
    |=> (!blank_o && $stable(trk)));
endmodule

bind pix_serializer pix_serializer_chk #(
  .PHASE_W(PHASE_W), .HALF_MASK(HALF_MASK), .QUARTER_MASK(QUARTER_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .depth_i(depth_i),
  .scale_i(scale_i), .phase_i(phase_i), .pix_o(pix_o), .blank_o(blank_o),
  .trk(trk)
);

// File: tb/pix_serializer_bench.sv
`timescale 1ns/1ps
module pix_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load = 1'b0;
  logic [7:0] byte_in = '0;
  logic [1:0] depth = '0;
  logic [1:0] scale = '0;
  logic [7:0] phase = '0;
  logic [3:0] pix;
  logic       blank;

  int n_tests = 0;
  int n_fail  = 0;

  logic [3:0] exp_pix_q[$];
  logic       exp_blank_q[$];
  string      tag_q[$];

  // reference state: pixel index into the current byte
  bit         m_act = 0;
  logic [7:0] m_byte = '0;
  int         m_idx = 0;
  logic [7:0] ring = 8'd1;

  always #2.5 clk = ~clk;

  pix_serializer u_pix_serializer (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .byte_i(byte_in),
    .depth_i(depth), .scale_i(scale), .phase_i(phase),
    .pix_o(pix), .blank_o(blank)
  );

  function automatic int nb_of(input logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 2 : 4;
  endfunction

  task automatic drive(input logic ld, input logic [7:0] b, input logic [1:0] d,
                       input logic [1:0] s, input logic [7:0] ph, input string tag);
    int nb;
    bit adv;
    logic [3:0] ep;
    @(negedge clk);
    load = ld; byte_in = b; depth = d; scale = s; phase = ph;
    nb  = nb_of(d);
    adv = (s == 2'b00) || (s == 2'b01 && (ph & 8'hAA) != 0) || (s[1] && (ph & 8'h88) != 0);
    if (ld) begin
      m_act = 1; m_byte = b; m_idx = 0;
    end else if (m_act && adv) begin
      m_idx++;
      if (m_idx * nb >= 8) m_act = 0;
    end
    ep = m_act ? 4'((m_byte >> (8 - nb * (m_idx + 1))) & ((1 << nb) - 1)) : 4'd0;
    exp_pix_q.push_back(ep);
    exp_blank_q.push_back(!m_act);
    tag_q.push_back(tag);
  endtask

  // one step on the rotating phase ring
  task automatic ring_step(input logic ld, input logic [7:0] b, input logic [1:0] d,
                           input logic [1:0] s, input string tag);
    drive(ld, b, d, s, ring, tag);
    ring = {ring[6:0], ring[7]};
  endtask

  task automatic idle(input int n, input logic [1:0] d, input logic [1:0] s, input string tag);
    for (int i = 0; i < n; i++) ring_step(1'b0, 8'h00, d, s, tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_pix_q.size() > 0) begin
        logic [3:0] ep;
        logic eb;
        string t;
        ep = exp_pix_q.pop_front();
        eb = exp_blank_q.pop_front();
        t  = tag_q.pop_front();
        n_tests++;
        if (pix !== ep || blank !== eb) begin
          n_fail++;
          $display("FAIL %s: pix=%0h blank=%0b expected pix=%0h blank=%0b", t, pix, blank, ep, eb);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (blank !== 1'b1 || pix !== 4'd0) begin
      n_fail++;
      $display("FAIL R1: pix=%0h blank=%0b expected pix=0 blank=1", pix, blank);
    end
    rst_ni = 1'b1;
    idle(3, 2'b00, 2'b00, "R1 idle after reset");

    // R2 R4 R5 R6: each depth at full rate, then blank (R3)
    ring_step(1'b1, 8'hB4, 2'b00, 2'b00, "R2 load depth1");
    idle(10, 2'b00, 2'b00, "R5 R6 depth1 pixels then R3 blank");
    ring_step(1'b1, 8'h6C, 2'b01, 2'b00, "R2 load depth2");
    idle(6, 2'b01, 2'b00, "R4 R5 depth2 pixels");
    ring_step(1'b1, 8'hA5, 2'b10, 2'b00, "R2 load depth4");
    idle(4, 2'b10, 2'b00, "R4 R5 depth4 pixels");
    ring_step(1'b1, 8'h3C, 2'b11, 2'b00, "R4 depth code 11");
    idle(4, 2'b11, 2'b00, "R4 depth code 11 pixels");

    // R7 R8: stretching on the phase ring
    ring_step(1'b1, 8'hE4, 2'b01, 2'b01, "R7 load scale2");
    idle(12, 2'b01, 2'b01, "R7 scale2 hold/advance");
    ring_step(1'b1, 8'h1D, 2'b00, 2'b01, "R7 load scale2 depth1");
    idle(20, 2'b00, 2'b01, "R7 scale2 depth1");
    ring_step(1'b1, 8'h3C, 2'b10, 2'b10, "R8 load scale4");
    idle(20, 2'b10, 2'b10, "R8 scale4 hold/advance");
    ring_step(1'b1, 8'h96, 2'b01, 2'b11, "R8 scale code 11");
    idle(36, 2'b01, 2'b11, "R8 scale code 11 run");

    // R9: load on the final advance edge
    ring_step(1'b1, 8'h1B, 2'b01, 2'b00, "R9 first byte");
    idle(3, 2'b01, 2'b00, "R9 first byte pixels");
    ring_step(1'b1, 8'hC9, 2'b01, 2'b00, "R9 no blank gap");
    idle(5, 2'b01, 2'b00, "R9 second byte pixels");

    // R10: mid-byte reload
    ring_step(1'b1, 8'hF0, 2'b00, 2'b00, "R10 first byte");
    idle(2, 2'b00, 2'b00, "R10 partial");
    ring_step(1'b1, 8'h0F, 2'b00, 2'b00, "R10 restart");
    idle(9, 2'b00, 2'b00, "R10 new byte pixels");

    // R11: phase ignored at full rate
    drive(1'b1, 8'h5A, 2'b00, 2'b00, 8'h00, "R11 load phase zero");
    for (int i = 0; i < 9; i++) drive(1'b0, 8'h00, 2'b00, 2'b00, 8'h00, "R11 advance with phase zero");

    // R3: idle with no load stays blank
    idle(6, 2'b10, 2'b01, "R3 idle blank");

    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule